// File: doc/BRIEF.md
# Gain-Ranging Sample Input Port

This block is the first stage of a digital receive chain. On every rising clock edge where the qualifier is high, it takes in three things: a 16-bit two's-complement mantissa, a 3-bit unsigned exponent and a one-bit channel-select line. The exponent is combined with a programmable offset to form a shift amount. An invert option can reverse the sense of the exponent, so that a converter whose exponent grows with signal strength can be matched. The mantissa is then shifted right arithmetically by that amount, and the result is presented one cycle later.

The block runs in one of three input modes. In single real mode the select line is ignored. In dual diversity mode the select line names the antenna channel. In complex mode the select line marks the sample as in-phase or quadrature. A small write-only register port sets the mode and the exponent controls. Every output sample carries a valid strobe, a tag and the mode it was captured under, so that downstream stages can steer it.

Top module: `gr_input_port`

## Requirements
- R1: After a synchronous active-high reset, out_valid, out_data, out_tag and out_mode are all 0. The mode is single real (code 0), and the offset and invert are 0. A sample with exponent 0 therefore passes through unchanged.
- R2: A sample taken with in_valid high appears on the outputs with out_valid high exactly one clock later. A cycle with in_valid low gives out_valid low one clock later.
- R3: With invert 0, the right shift equals (exponent + offset) mod 8.
- R4: With invert 1, the right shift equals (7 − exponent + offset) mod 8.
- R5: The shift is arithmetic. The sign bit is replicated, the shifted-out low bits are dropped, and the output stays 16 bits wide.
- R6: A write to address 1 loads the exponent control register. The offset is taken from data bits 7:5 and invert from bit 4, and bits 3:0 have no effect.
- R7: A write to address 0 loads the mode from data bits 1:0, where 0 is single real, 1 is diversity and 2 is complex. A write of code 3 leaves the mode unchanged.
- R8: In single real mode, out_tag is 0 whatever in_ab carries.
- R9: In diversity mode, out_tag equals the captured in_ab, where 0 means channel A and 1 means channel B.
- R10: In complex mode, out_tag equals the captured in_ab, where 0 means in-phase and 1 means quadrature.
- R11: A register write and a sample in the same cycle: the sample is scaled and tagged with the settings that held before the write. The new settings apply from the next sample.
- R12: out_mode reports the mode code under which the presented sample was captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample and register clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register select: 0 mode, 1 exponent control |
| cfg_wdata | input | 8 | Register write data |
| in_valid | input | 1 | Sample qualifier |
| in_mant | input | 16 | Two's-complement mantissa |
| in_exp | input | 3 | Unsigned exponent |
| in_ab | input | 1 | Channel / I-Q select line |
| out_valid | output | 1 | Scaled sample valid |
| out_data | output | 16 | Scaled sample |
| out_tag | output | 1 | Channel or I/Q tag |
| out_mode | output | 2 | Mode the sample was captured under |

## Verification
Two functions can act in the same cycle: a register write and a sample capture. The bench provokes this by raising cfg_we and in_valid in the same cycle, once for an invert change and once for a mode change. It then expects the captured sample to show the old shift, tag and mode code. A second sample taken one cycle later must show the new settings.

// File: rtl/grip_pkg.sv
package grip_pkg;
    localparam int MANT_W  = 16;
    localparam int EXP_W   = 3;
    localparam int REG_W   = 8;
    localparam int ADDR_W  = 1;
    localparam int MODE_W  = 2;
    localparam int OFF_LSB = 5;
    localparam int INV_BIT = 4;
    localparam logic [ADDR_W-1:0] ADDR_MODE = 1'b0;
    localparam logic [ADDR_W-1:0] ADDR_EXPC = 1'b1;

    typedef enum logic [MODE_W-1:0] {
        MODE_REAL = 2'd0,
        MODE_DIV  = 2'd1,
        MODE_CPLX = 2'd2
    } grip_mode_e;

    typedef struct packed {
        logic [EXP_W-1:0] off;
        logic             inv;
    } grip_expc_t;

    typedef struct packed {
        logic              valid;
        grip_mode_e        mode;
        logic              tag;
        logic [MANT_W-1:0] data;
    } grip_samp_t;

    // Inverted exponent (2^W-1 - e) is the bitwise complement; the sum wraps mod 2^W.
    function automatic logic [EXP_W-1:0] shift_amt(input logic [EXP_W-1:0] e,
                                                   input grip_expc_t c);
        logic [EXP_W-1:0] base;
        base = c.inv ? ~e : e;
        return base + c.off;
    endfunction

    function automatic logic mode_legal(input logic [MODE_W-1:0] m);
        return (m == MODE_REAL) || (m == MODE_DIV) || (m == MODE_CPLX);
    endfunction
endpackage

// File: rtl/grip_cfg_regs.sv
module grip_cfg_regs
    import grip_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output grip_mode_e        mode,
    output grip_expc_t        expc
);
    logic [MODE_W-1:0] mode_code;
    assign mode_code = wdata[MODE_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= MODE_REAL;
            expc <= '0;
        end else if (we) begin
            if (addr == ADDR_MODE && mode_legal(mode_code)) begin
                mode <= grip_mode_e'(mode_code);
            end
            if (addr == ADDR_EXPC) begin
                expc.off <= wdata[OFF_LSB +: EXP_W];
                expc.inv <= wdata[INV_BIT];
            end
        end
    end

    assert_mode_legal_R7: assert property (@(posedge clk) disable iff (rst)
        mode_legal(mode));

    assert_expc_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !(we && addr == ADDR_EXPC) |=> $stable(expc));

    assert_mode_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !(we && addr == ADDR_MODE) |=> $stable(mode));
endmodule

// File: rtl/grip_scaler.sv
module grip_scaler
    import grip_pkg::*;
(
    input  logic [MANT_W-1:0] mant,
    input  logic [EXP_W-1:0]  expo,
    input  grip_expc_t        expc,
    output logic [MANT_W-1:0] scaled
);
    logic [EXP_W-1:0] sh;
    always_comb begin
        sh     = shift_amt(expo, expc);
        scaled = $unsigned($signed(mant) >>> sh);
    end
endmodule

// File: rtl/grip_router.sv
module grip_router
    import grip_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_ab,
    input  grip_mode_e        mode,
    input  logic [MANT_W-1:0] scaled,
    output grip_samp_t        samp
);
    logic tag_nxt;
    always_comb begin
        case (mode)
            MODE_DIV:  tag_nxt = in_ab;
            MODE_CPLX: tag_nxt = in_ab;
            default:   tag_nxt = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            samp <= '0;
        end else begin
            samp.valid <= in_valid;
            if (in_valid) begin
                samp.mode <= mode;
                samp.tag  <= tag_nxt;
                samp.data <= scaled;
            end
        end
    end

    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> samp.valid);

    assert_idle_latency_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !samp.valid);

    assert_real_tag_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (samp.valid && samp.mode == MODE_REAL) |-> !samp.tag);

    assert_tag_follows_ab_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode != MODE_REAL) |=> samp.tag == $past(in_ab));
endmodule

// File: rtl/gr_input_port.sv
module gr_input_port
    import grip_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              in_valid,
    input  logic [MANT_W-1:0] in_mant,
    input  logic [EXP_W-1:0]  in_exp,
    input  logic              in_ab,
    output logic              out_valid,
    output logic [MANT_W-1:0] out_data,
    output logic              out_tag,
    output logic [MODE_W-1:0] out_mode
);
    grip_mode_e        mode;
    grip_expc_t        expc;
    logic [MANT_W-1:0] scaled;
    grip_samp_t        samp;

    grip_cfg_regs u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .mode(mode), .expc(expc)
    );

    grip_scaler u_scale (
        .mant(in_mant), .expo(in_exp), .expc(expc), .scaled(scaled)
    );

    grip_router u_route (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ab(in_ab),
        .mode(mode), .scaled(scaled), .samp(samp)
    );

    assign out_valid = samp.valid;
    assign out_data  = samp.data;
    assign out_tag   = samp.tag;
    assign out_mode  = samp.mode;

    assert_sign_kept_R5: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_data[MANT_W-1] == $past(in_mant[MANT_W-1]));

    assert_mode_reported_R12: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_mode == $past(mode));
endmodule

// File: tb/gr_input_port_tb.sv
module gr_input_port_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [0:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        in_valid = 1'b0;
    logic [15:0] in_mant = '0;
    logic [2:0]  in_exp = '0;
    logic        in_ab = 1'b0;
    logic        out_valid;
    logic [15:0] out_data;
    logic        out_tag;
    logic [1:0]  out_mode;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;

    gr_input_port u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_mant(in_mant),
        .in_exp(in_exp), .in_ab(in_ab), .out_valid(out_valid),
        .out_data(out_data), .out_tag(out_tag), .out_mode(out_mode)
    );

    // {mode[2], ctl[8], exp[3], ab[1], mant[16], exp_data[16], exp_tag[1]}
    localparam int NV = 9;
    localparam logic [46:0] VEC [NV] = '{
        {2'd0, 8'h00, 3'd0, 1'b1, 16'h1234, 16'h1234, 1'b0}, // R8 pass-through
        {2'd0, 8'h00, 3'd5, 1'b0, 16'h4000, 16'h0200, 1'b0}, // R3 shift 5
        {2'd0, 8'h00, 3'd5, 1'b0, 16'h8000, 16'hFC00, 1'b0}, // R5 sign fill
        {2'd0, 8'h10, 3'd5, 1'b0, 16'h4000, 16'h1000, 1'b0}, // R4 shift 2
        {2'd0, 8'h10, 3'd0, 1'b1, 16'h7FFF, 16'h00FF, 1'b0}, // R4 shift 7
        {2'd1, 8'h60, 3'd6, 1'b1, 16'h0100, 16'h0080, 1'b1}, // R3 wrap, R9
        {2'd2, 8'hB0, 3'd1, 1'b0, 16'hF000, 16'hFE00, 1'b0}, // R4 wrap, R10
        {2'd2, 8'hB0, 3'd1, 1'b1, 16'hFFFF, 16'hFFFF, 1'b1}, // R5, R10
        {2'd1, 8'h0F, 3'd2, 1'b0, 16'h0040, 16'h0010, 1'b0}  // R6 low bits, R9
    };

    task automatic check(input string req, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic wr(input logic [0:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic samp(input logic [2:0] e, input logic ab, input logic [15:0] m);
        in_valid = 1'b1; in_exp = e; in_ab = ab; in_mant = m;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<50000", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 valid", out_valid, 0);
        check("R1 data", out_data, 0);
        check("R1 tag", out_tag, 0);
        check("R1 mode", out_mode, 0);
        samp(3'd0, 1'b1, 16'hA5A5);
        check("R1 default passthrough", out_data, 16'hA5A5);
        check("R1 default tag", out_tag, 0);
        check("R2 valid after sample", out_valid, 1);
        @(negedge clk);
        check("R2 idle gives no valid", out_valid, 0);

        for (int i = 0; i < NV; i++) begin
            wr(1'b0, {6'd0, VEC[i][46:45]});
            wr(1'b1, VEC[i][44:37]);
            samp(VEC[i][36:34], VEC[i][33], VEC[i][32:17]);
            check("R2 vec valid", out_valid, 1);
            check("R3 R4 R5 vec data", out_data, VEC[i][16:1]);
            check("R8 R9 R10 vec tag", out_tag, VEC[i][0]);
            check("R12 vec mode", out_mode, VEC[i][46:45]);
        end

        // R7: illegal code 3 keeps diversity mode
        wr(1'b0, 8'h01);
        wr(1'b0, 8'h03);
        wr(1'b1, 8'h00);
        samp(3'd0, 1'b1, 16'h0001);
        check("R7 code 3 ignored mode", out_mode, 1);
        check("R7 code 3 ignored tag", out_tag, 1);

        // R11: write and sample in the same cycle
        wr(1'b0, 8'h00);
        cfg_we = 1'b1; cfg_addr = 1'b1; cfg_wdata = 8'h10;
        samp(3'd5, 1'b0, 16'h4000);
        cfg_we = 1'b0;
        check("R11 old setting used", out_data, 16'h0200);
        samp(3'd5, 1'b0, 16'h4000);
        check("R11 new setting next", out_data, 16'h1000);
        cfg_we = 1'b1; cfg_addr = 1'b0; cfg_wdata = 8'h02;
        samp(3'd0, 1'b1, 16'h0100);
        cfg_we = 1'b0;
        check("R11 old mode tag", out_tag, 0);
        check("R11 R12 old mode code", out_mode, 0);
        samp(3'd0, 1'b1, 16'h0100);
        check("R10 R11 new mode tag", out_tag, 1);
        check("R12 new mode code", out_mode, 2);

        finish_run();
    end
endmodule